// File: doc/BRIEF.md
# Two-Bit Cursor Sprite Overlay

This block lays a 32-pixel-wide pointer sprite over a video pixel stream. The stream carries two pixels per clock tick. Each sprite pixel is two bits wide.

At the start of every line on which the cursor is vertically active, a loader fetches eight consecutive bytes of sprite image from memory. It reads them at a running cursor address, which is reloaded from a base pointer when the vertical display phase begins. While the line is being drawn, a pixel pointer is armed when the horizontal counter reaches a programmed pixel position. The pointer then walks through the sprite two pixels per tick.

Sprite pixels with a code of 0 are transparent. Codes 1 to 3 replace the incoming pixel with one of three 12-bit colours. The overlay acts over border and active display, but never during sync or blank. It is held transparent until the line's image load is complete. Memory arbitration stays outside the block: the loader raises a request and takes a byte on each cycle the memory acknowledges.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, `pix0_out`, `pix1_out`, `load_busy` and `mem_req` are all 0.
- R2: A tick with `line_start` high and `vcur_active` high starts a load. `load_busy` and `mem_req` are high from the next cycle. With `mem_ack` held high, they stay high for exactly 8 cycles and then fall. A `line_start` with `vcur_active` low starts no load.
- R3: `frame_start` loads the cursor address counter from `cur_base`. Each completed line load reads the 8 bytes at counter, counter+1, ..., counter+7, in that order, leaving the counter advanced by 8. A line with `vcur_active` low leaves the counter unchanged. `mem_addr` holds steady while a request waits without an acknowledge.
- R4: Sprite pixel n (0..31) is taken from fetched byte n/4, at bits [2*(n%4)+1 : 2*(n%4)], so the lowest bit pair of a byte is the leftmost pixel. Code 0 passes the incoming pixel through. Code c in 1..3 outputs `cur_colours[(c-1)*12 +: 12]`.
- R5: The trigger tick is the tick of a cursor-active line on which `h_pos == h_start[10:1]`, that is, the tick whose pixel pair holds pixel `h_start`. On that tick the pointer is loaded with `h_start[0] - 5`. On every later tick it rises by 2, until it reaches 32 or more.
- R6: Within a tick, `pix0` shows sprite pixel pointer+0 and `pix1` shows sprite pixel pointer+1. Each lane is drawn only when its own index lies in 0..31, so a sprite edge may fall between the two lanes.
- R7: When `pix_visible` is low (sync or blank), both outputs equal the incoming pixels.
- R8: While `load_busy` is high, the overlay is transparent.
- R9: On the `line_start` tick itself, on lines where `vcur_active` was low at line start, and before the trigger tick, the outputs equal the inputs.
- R10: Outputs are registered. The pair presented on a tick appears at the outputs after that tick's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Vertical display phase begins; reload the cursor address counter |
| line_start | input | 1 | First tick of a new line |
| vcur_active | input | 1 | Cursor is vertically active on the line that is starting |
| cur_base | input | AW | Programmed cursor image base address |
| h_pos | input | HW | Horizontal tick counter, two pixels per tick |
| h_start | input | HW+1 | Cursor horizontal trigger position in pixels |
| pix_visible | input | 1 | Border or active display (not sync or blank) |
| cur_colours | input | 36 | Three 12-bit cursor colours, code 1 in the low bits |
| pix0_in | input | 12 | Left pixel of the incoming pair |
| pix1_in | input | 12 | Right pixel of the incoming pair |
| mem_req | output | 1 | Image byte request |
| mem_addr | output | AW | Image byte address |
| mem_ack | input | 1 | Memory delivers `mem_rdata` this cycle |
| mem_rdata | input | 8 | Image byte |
| load_busy | output | 1 | Line image load in progress |
| pix0_out | output | 12 | Left output pixel |
| pix1_out | output | 12 | Right output pixel |

## Verification
The hardest situation to reach is a trigger whose pointer starts at an odd, negative offset. In that case the sprite's first or last pixel lands in only one lane of a pair, and the two lanes must be judged separately. The bench sweeps every trigger position from 0 to 63, plus the far end of the line, so both trigger parities occur at every pair alignment. A second case, a trigger that arrives while the image load is still running, is reached by placing the trigger within the first eight ticks after line start. Visibility gaps and a pseudo-random image let transparency, the three colours and blanking all meet the sprite's edges.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    localparam int unsigned RGB_W     = 12;
    localparam int unsigned CODE_W    = 2;
    localparam int unsigned N_COLOURS = 3;

    typedef logic [RGB_W-1:0] rgb_t;

    typedef struct packed {
        rgb_t p0;
        rgb_t p1;
    } pix_pair_t;
endpackage

// File: rtl/cursor_fetch.sv
module cursor_fetch #(
    parameter int unsigned AW        = 16,
    parameter int unsigned IMG_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_start,
    input  logic                   line_start,
    input  logic                   line_load,
    input  logic [AW-1:0]          base,
    input  logic                   mem_ack,
    input  logic [7:0]             mem_rdata,
    output logic                   mem_req,
    output logic [AW-1:0]          mem_addr,
    output logic                   busy,
    output logic [IMG_BYTES*8-1:0] image
);
    localparam int unsigned CNT_W = (IMG_BYTES > 1) ? $clog2(IMG_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IMG_BYTES - 1);

    typedef struct packed {
        logic [AW-1:0]          addr;
        logic [CNT_W-1:0]       cnt;
        logic                   busy;
        logic [IMG_BYTES*8-1:0] image;
    } fetch_t;

    fetch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.busy && mem_ack) begin
            st_d.image[{st_q.cnt, 3'b000} +: 8] = mem_rdata;
            st_d.addr = st_q.addr + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (line_start) begin
            st_d.busy = line_load;
            st_d.cnt  = '0;
        end
        if (frame_start) begin
            st_d.addr = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_req  = st_q.busy;
    assign mem_addr = st_q.addr;
    assign busy     = st_q.busy;
    assign image    = st_q.image;
endmodule

// File: rtl/cursor_track.sv
module cursor_track #(
    parameter int unsigned HW         = 10,
    parameter int unsigned CUR_PIX    = 32,
    parameter int          TRIG_DELAY = 5,
    parameter int unsigned PTR_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    line_start,
    input  logic                    vact_in,
    input  logic [HW-1:0]           h_pos,
    input  logic [HW:0]             h_start,
    output logic signed [PTR_W-1:0] ptr_now,
    output logic                    line_act
);
    localparam logic signed [PTR_W-1:0] IDLE     = PTR_W'(CUR_PIX);
    localparam logic signed [PTR_W-1:0] OFF_EVEN = PTR_W'(-TRIG_DELAY);
    localparam logic signed [PTR_W-1:0] OFF_ODD  = PTR_W'(1 - TRIG_DELAY);
    localparam logic signed [PTR_W-1:0] STEP     = PTR_W'(2);

    typedef struct packed {
        logic signed [PTR_W-1:0] ptr;
        logic                    act;
    } track_t;

    track_t st_d, st_q;
    logic   hit;
    logic signed [PTR_W-1:0] eff;

    always_comb begin
        hit = st_q.act && (h_pos == h_start[HW:1]);
        if (line_start)        eff = IDLE;
        else if (hit)          eff = h_start[0] ? OFF_ODD : OFF_EVEN;
        else if (st_q.ptr < IDLE) eff = st_q.ptr + STEP;
        else                   eff = st_q.ptr;
        st_d     = st_q;
        st_d.ptr = eff;
        if (line_start) st_d.act = vact_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ptr: IDLE, act: 1'b0};
        else        st_q <= st_d;
    end

    assign ptr_now  = eff;
    assign line_act = st_q.act;
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
    import cursor_pkg::*;
#(
    parameter int unsigned CUR_PIX = 32,
    parameter int unsigned PTR_W   = 8,
    parameter int unsigned LANES   = 2
) (
    input  logic signed [PTR_W-1:0]      ptr,
    input  logic                         enable,
    input  logic [CUR_PIX*CODE_W-1:0]    image,
    input  logic [N_COLOURS*RGB_W-1:0]   colours,
    input  logic [LANES*RGB_W-1:0]       pix_in,
    output logic [LANES*RGB_W-1:0]       pix_out
);
    localparam int unsigned IW = $clog2(CUR_PIX);
    localparam logic signed [PTR_W-1:0] LIMIT = PTR_W'(CUR_PIX);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [PTR_W-1:0] idx;
        logic                    in_range;
        logic [CODE_W-1:0]       code;
        rgb_t                    src;
        rgb_t                    res;

        always_comb begin
            idx      = ptr + PTR_W'(g);
            in_range = !idx[PTR_W-1] && (idx < LIMIT);
            code     = image[{idx[IW-1:0], 1'b0} +: CODE_W];
            src      = pix_in[g*RGB_W +: RGB_W];
            res      = src;
            if (enable && in_range) begin
                case (code)
                    2'd1:    res = colours[0*RGB_W +: RGB_W];
                    2'd2:    res = colours[1*RGB_W +: RGB_W];
                    2'd3:    res = colours[2*RGB_W +: RGB_W];
                    default: res = src;
                endcase
            end
        end

        assign pix_out[g*RGB_W +: RGB_W] = res;
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int unsigned AW         = 16,
    parameter int unsigned HW         = 10,
    parameter int unsigned CUR_PIX    = 32,
    parameter int          TRIG_DELAY = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_start,
    input  logic                       line_start,
    input  logic                       vcur_active,
    input  logic [AW-1:0]              cur_base,
    input  logic [HW-1:0]              h_pos,
    input  logic [HW:0]                h_start,
    input  logic                       pix_visible,
    input  logic [N_COLOURS*RGB_W-1:0] cur_colours,
    input  logic [RGB_W-1:0]           pix0_in,
    input  logic [RGB_W-1:0]           pix1_in,
    output logic                       mem_req,
    output logic [AW-1:0]              mem_addr,
    input  logic                       mem_ack,
    input  logic [7:0]                 mem_rdata,
    output logic                       load_busy,
    output logic [RGB_W-1:0]           pix0_out,
    output logic [RGB_W-1:0]           pix1_out
);
    localparam int unsigned IMG_BYTES = CUR_PIX * CODE_W / 8;
    localparam int unsigned PTR_W     = $clog2(CUR_PIX) + 3;

    logic [IMG_BYTES*8-1:0]  image;
    logic                    busy;
    logic signed [PTR_W-1:0] ptr;
    logic                    line_act;
    logic [2*RGB_W-1:0]      mixed;
    pix_pair_t               out_d, out_q;

    cursor_fetch #(.AW(AW), .IMG_BYTES(IMG_BYTES)) u_fetch (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_start(line_start), .line_load(vcur_active), .base(cur_base),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .busy(busy), .image(image)
    );

    cursor_track #(.HW(HW), .CUR_PIX(CUR_PIX), .TRIG_DELAY(TRIG_DELAY), .PTR_W(PTR_W)) u_track (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .vact_in(vcur_active),
        .h_pos(h_pos), .h_start(h_start), .ptr_now(ptr), .line_act(line_act)
    );

    cursor_mix #(.CUR_PIX(CUR_PIX), .PTR_W(PTR_W), .LANES(2)) u_mix (
        .ptr(ptr), .enable(line_act && !busy && pix_visible), .image(image),
        .colours(cur_colours), .pix_in({pix1_in, pix0_in}), .pix_out(mixed)
    );

    always_comb begin
        out_d.p0 = mixed[0 +: RGB_W];
        out_d.p1 = mixed[RGB_W +: RGB_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign load_busy = busy;
    assign pix0_out  = out_q.p0;
    assign pix1_out  = out_q.p1;
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic          line_start,
    input logic          vcur_active,
    input logic          pix_visible,
    input logic [11:0]   pix0_in,
    input logic [11:0]   pix1_in,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          load_busy,
    input logic [11:0]   pix0_out,
    input logic [11:0]   pix1_out
);
    // R2
    load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (load_busy == $past(vcur_active)));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_busy && !mem_ack && !line_start && !frame_start) |=> $stable(mem_addr));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_busy && mem_ack && !frame_start) |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));

    // R7
    blank_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_visible |=> (pix0_out == $past(pix0_in) && pix1_out == $past(pix1_in)));

    // R8
    busy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_busy |=> (pix0_out == $past(pix0_in) && pix1_out == $past(pix1_in)));

    // R9
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (pix0_out == $past(pix0_in) && pix1_out == $past(pix1_in)));
endmodule

bind cursor_overlay cursor_overlay_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .vcur_active(vcur_active), .pix_visible(pix_visible), .pix0_in(pix0_in),
    .pix1_in(pix1_in), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .load_busy(load_busy), .pix0_out(pix0_out), .pix1_out(pix1_out)
);

// File: tb/cursor_overlay_tb.sv
module cursor_overlay_tb;
    localparam int AW = 16;
    localparam int HW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          line_start = 1'b0;
    logic          vcur_active = 1'b0;
    logic [AW-1:0] cur_base = '0;
    logic [HW-1:0] h_pos = '0;
    logic [HW:0]   h_start = '0;
    logic          pix_visible = 1'b0;
    logic [35:0]   cur_colours;
    logic [11:0]   pix0_in = '0, pix1_in = '0;
    logic          mem_req, mem_ack, load_busy;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic [11:0]   pix0_out, pix1_out;

    int checks = 0;
    int errors = 0;
    int exp_addr = 0;
    bit done = 1'b0;

    localparam logic [11:0] COL1 = 12'h1A1, COL2 = 12'h2B2, COL3 = 12'h3C3;
    assign cur_colours = {COL3, COL2, COL1};

    always #4 clk = ~clk;

    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 29) ^ ((a >> 3) * 7) ^ 5);
    endfunction

    assign mem_ack   = mem_req;
    assign mem_rdata = mem_byte(int'(mem_addr));

    cursor_overlay #(.AW(AW), .HW(HW)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .vcur_active(vcur_active), .cur_base(cur_base), .h_pos(h_pos), .h_start(h_start),
        .pix_visible(pix_visible), .cur_colours(cur_colours), .pix0_in(pix0_in),
        .pix1_in(pix1_in), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .load_busy(load_busy), .pix0_out(pix0_out), .pix1_out(pix1_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic load_frame(input int b);
        @(negedge clk);
        frame_start = 1'b1;
        cur_base = AW'(b);
        @(negedge clk);
        frame_start = 1'b0;
        exp_addr = b;
    endtask

    // One line: the line_start tick, then ticks 1..nticks with h_pos = t-1.
    task automatic run_line(input bit vact, input int hs, input int nticks, input int vis_mode);
        int la;
        int ptr;
        la = exp_addr;
        @(negedge clk);
        line_start = 1'b1;
        vcur_active = vact;
        h_pos = '1;
        h_start = (HW+1)'(hs);
        pix_visible = 1'b1;
        pix0_in = 12'(hs * 3 + 1);
        pix1_in = 12'(hs * 5 + 2);
        @(posedge clk);
        #1;
        // R9: line_start tick passes pixels through
        check(pix0_out == 12'(hs * 3 + 1) && pix1_out == 12'(hs * 5 + 2), "R9",
              int'(pix0_out), hs * 3 + 1);
        // R2: load begins only on cursor-active lines
        check(load_busy == vact && mem_req == vact, "R2", int'(load_busy), int'(vact));
        // R3: first byte address is the running counter
        if (vact) check(mem_addr == AW'(la), "R3", int'(mem_addr), la);
        if (vact) exp_addr = la + 8;
        ptr = 32;
        for (int t = 1; t <= nticks; t++) begin
            int e0, e1, in0, in1;
            bit vis, busy_m;
            @(negedge clk);
            line_start = 1'b0;
            vcur_active = 1'b0;
            h_pos = HW'(t - 1);
            in0 = (t * 13 + hs) & 12'hFFF;
            in1 = (t * 91 + 7) & 12'hFFF;
            pix0_in = 12'(in0);
            pix1_in = 12'(in1);
            vis = (vis_mode == 0) ? 1'b1 : (((t / 3) % 4) != 0);
            pix_visible = vis;
            busy_m = vact && (t <= 8);
            if (vact && (t - 1) == (hs >> 1)) ptr = (hs & 1) - 5;
            else if (ptr < 32) ptr += 2;
            e0 = in0;
            e1 = in1;
            for (int k = 0; k < 2; k++) begin
                int idx, code, col;
                idx = ptr + k;
                if (vact && !busy_m && vis && idx >= 0 && idx < 32) begin
                    code = (int'(mem_byte(la + idx / 4)) >> (2 * (idx % 4))) & 3;
                    col = (code == 1) ? int'(COL1) : (code == 2) ? int'(COL2) : int'(COL3);
                    if (code != 0) begin
                        if (k == 0) e0 = col;
                        else e1 = col;
                    end
                end
            end
            @(posedge clk);
            #1;
            // R4 R5 R6 R7 R8 R10: pixel values one edge after presentation
            check(pix0_out == 12'(e0), "R4/R5 lane0", int'(pix0_out), e0);
            check(pix1_out == 12'(e1), "R6 lane1", int'(pix1_out), e1);
            if (vact && t == 7) check(load_busy == 1'b1, "R2 busy", int'(load_busy), 1);
            if (vact && t == 8) check(load_busy == 1'b0 && mem_req == 1'b0, "R2 done",
                                      int'(load_busy), 0);
        end
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(pix0_out == 0 && pix1_out == 0, "R1 pix", int'(pix0_out), 0);
        check(load_busy == 0 && mem_req == 0, "R1 busy", int'(load_busy), 0);
        rst_n = 1'b1;
        load_frame(16'h1230);
        // R9: inactive line draws nothing and leaves the counter
        run_line(1'b0, 10, 40, 0);
        // R5 R6: sweep every trigger position of both parities
        for (int hs = 0; hs < 64; hs++) run_line(1'b1, hs, hs / 2 + 30, hs % 2);
        run_line(1'b0, 20, 40, 0);
        // R3: counter reload from a new base
        load_frame(16'h0400);
        run_line(1'b1, 30, 50, 0);
        run_line(1'b1, 2000, 1024, 0);
        run_line(1'b1, 2047, 1024, 1);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule